// File: doc/BRIEF.md
# Serial ADC Interface Device Model

This block models the digital side of an eight-input, 10-bit successive-approximation converter as seen from its four-wire serial port. Working in a fast system clock domain, it oversamples chip select, serial clock and serial data. It waits for a start bit and collects an 8-bit command. From the command it decodes the input selection, the output coding and the clock mode, then schedules the acquire and hold instants. The analog front end is represented by digital codes on `ch_code` and `com_code`. The conversion result is formed from those codes at the hold instant.

In external clock mode the serial clock paces the conversion. The strobe pin flags the slot just before the result, and the result leaves MSB first on falling serial clock edges. In internal clock mode a fixed cycle counter stands in for the conversion. The strobe reads low while the counter runs and high once it has finished, and the result is then clocked out. Tri-state enables for the data and strobe pins are provided as separate outputs so that a pad ring can use them.

Top module: `adc_serial_dev`

## Requirements
- R1: While `cs_n` is low, `din` is sampled on each rising `sclk`. Zeros that arrive before the first 1 are ignored, and that first 1 is bit 7 of the command.
- R2: Command bits 7..0 are: start, sel[2:0], uni (1 = unipolar), sgl (1 = single-ended), pm[1:0]. pm 11 is external clock, pm 10 is internal clock, and pm 00 or 01 is a power-down byte.
- R3: The positive input is channel {sel[1],sel[0],sel[2]}. In single-ended mode the negative input is `com_code`. In differential mode the negative input is the other channel of the same pair, {sel[1],sel[0],~sel[2]}.
- R4: The result is the positive code minus the negative code. In unipolar mode it is clamped to 0..1023 and given as straight binary. In bipolar mode it is clamped to -512..511 and given in two's complement.
- R5: `acq` rises on the falling `sclk` after command bit 5 and falls on the falling `sclk` after command bit 8. The result is captured at that second edge.
- R6: In external clock mode `sstrb` is high for exactly one `sclk` period, from the falling edge after bit 8 to the next falling edge.
- R7: In external clock mode, `dout` presents one zero slot, then result bits 9..0, then two zero sub-LSB bits, then zeros. Each bit changes only on a falling `sclk`.
- R8: `dout_oe` is high exactly while `cs_n` is low. `sstrb_oe` follows `cs_n` unless internal clock mode is selected. After `cs_n` falls in external mode, `sstrb` is driven low.
- R9: In internal clock mode `sstrb` goes low at the hold edge and stays low for CONV_CYCLES clocks. Serial clock edges are ignored during that time. `sstrb` then goes high with result bit 9 on `dout`, and each later falling `sclk` shifts out the next bit, including two zero sub-LSB bits.
- R10: Raising `cs_n` during the command or during an external read aborts it, and the block returns to start-bit search.
- R11: A power-down byte produces no strobe and no data, and start-bit search resumes at once.
- R12: After reset, `dout`, `sstrb`, `acq` and both enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial command input |
| ch_code | input | 80 | Eight 10-bit input codes, channel i at bits [10i+9:10i] |
| com_code | input | 10 | Common reference input code |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for dout |
| sstrb | output | 1 | Strobe / busy-done flag |
| sstrb_oe | output | 1 | Drive enable for sstrb |
| acq | output | 1 | Track window of the sample-and-hold |

## Verification
The hardest situation to reach is internal clock mode with serial clock activity during the busy window. The stimulus toggles `sclk` with `din` held high while the counter runs, then checks that the strobe is still low and that, once it rises, the result frame is intact. A second difficult point is the change between modes within one chip-select frame. The stimulus sends a power-down byte right after an internal conversion, so the strobe has to fall from its done level. It then sends an external conversion in the same frame. Aborts are produced by raising chip select partway through a result, then checking that the next command on a different channel returns its own code.

// File: rtl/adc_sdev_pkg.sv
package adc_sdev_pkg;
  localparam int CTRL_BITS = 8;
  localparam int NUM_CH    = 8;
  localparam int SEL_W     = 3;
  localparam int PAD_BITS  = 2;
  localparam int TRACK_AT  = CTRL_BITS - 3;

  typedef enum logic [2:0] {
    ST_SEARCH,
    ST_CTRL,
    ST_EXT,
    ST_IBUSY,
    ST_IOUT
  } sdev_state_e;

  typedef enum logic [1:0] {
    PM_FULL_OFF = 2'b00,
    PM_FAST_OFF = 2'b01,
    PM_INT_CLK  = 2'b10,
    PM_EXT_CLK  = 2'b11
  } pmode_e;

  typedef struct packed {
    logic             start;
    logic [SEL_W-1:0] sel;
    logic             uni;
    logic             sgl;
    logic [1:0]       pmode;
  } ctrl_byte_t;
endpackage

// File: rtl/adc_sdev_edges.sv
module adc_sdev_edges (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  output logic sclk_rise,
  output logic sclk_fall
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk;
  end

  assign sclk_rise = sclk & ~sclk_q;
  assign sclk_fall = ~sclk & sclk_q;
endmodule

// File: rtl/adc_sdev_result.sv
module adc_sdev_result
  import adc_sdev_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic [SEL_W-1:0]        sel,
  input  logic                    uni,
  input  logic                    sgl,
  input  logic [NUM_CH*RES_W-1:0] ch_code,
  input  logic [RES_W-1:0]        com_code,
  output logic [RES_W-1:0]        code
);
  localparam int DW = RES_W + 1;
  localparam logic signed [DW-1:0] BIP_MAX = DW'((2 ** (RES_W - 1)) - 1);
  localparam logic signed [DW-1:0] BIP_MIN = -BIP_MAX - DW'(1);

  logic [RES_W-1:0] ch_arr [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign ch_arr[g] = ch_code[g*RES_W +: RES_W];
  end

  logic [SEL_W-1:0]        pos_idx, neg_idx;
  logic [RES_W-1:0]        pos_v, neg_v;
  logic signed [DW-1:0]    diff;

  always_comb begin
    pos_idx = {sel[1:0], sel[2]};
    neg_idx = {sel[1:0], ~sel[2]};
    pos_v   = ch_arr[pos_idx];
    neg_v   = sgl ? com_code : ch_arr[neg_idx];
    diff    = $signed({1'b0, pos_v}) - $signed({1'b0, neg_v});
    if (uni) begin
      code = (diff < 0) ? '0 : diff[RES_W-1:0];
    end else if (diff > BIP_MAX) begin
      code = BIP_MAX[RES_W-1:0];
    end else if (diff < BIP_MIN) begin
      code = BIP_MIN[RES_W-1:0];
    end else begin
      code = diff[RES_W-1:0];
    end
  end
endmodule

// File: rtl/adc_sdev_serializer.sv
module adc_sdev_serializer #(
  parameter int CODE_W = 10,
  parameter int PAD_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [CODE_W-1:0] code,
  output logic              head,
  output logic              last
);
  localparam int FRAME_W = CODE_W + PAD_W;
  localparam int CW      = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr;
  logic [CW-1:0]      cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      cnt <= '0;
    end else if (load) begin
      sr  <= {code, {PAD_W{1'b0}}};
      cnt <= '0;
    end else if (shift) begin
      sr  <= {sr[FRAME_W-2:0], 1'b0};
      cnt <= cnt + CW'(1);
    end
  end

  assign head = sr[FRAME_W-1];
  assign last = (cnt == CW'(FRAME_W - 1));

  // R7: the controller never asks for more bits than one frame holds
  p_frame_cnt_r7: assert property (@(posedge clk) disable iff (rst)
    shift |-> (cnt < CW'(FRAME_W)));

  // R7: once the code bits are gone only zero padding is presented
  p_pad_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt >= CW'(CODE_W)) |-> !head);
endmodule

// File: rtl/adc_serial_dev.sv
module adc_serial_dev
  import adc_sdev_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int CONV_CYCLES = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_n,
  input  logic                    sclk,
  input  logic                    din,
  input  logic [NUM_CH*RES_W-1:0] ch_code,
  input  logic [RES_W-1:0]        com_code,
  output logic                    dout,
  output logic                    dout_oe,
  output logic                    sstrb,
  output logic                    sstrb_oe,
  output logic                    acq
);
  localparam int CNT_W  = $clog2(CONV_CYCLES + 1);
  localparam int BCNT_W = $clog2(CTRL_BITS + 1);

  sdev_state_e         state;
  logic [CTRL_BITS-1:0] ctrl_sr;
  logic [BCNT_W-1:0]   ctrl_cnt;
  logic [CNT_W-1:0]    busy_cnt;
  logic                int_mode;
  ctrl_byte_t          cb;

  logic sclk_rise, sclk_fall, fire_rise, fire_fall;
  logic busy_done, latch, ser_load, ser_shift, ser_head, ser_last;
  logic [RES_W-1:0] res_code;

  assign cb = ctrl_byte_t'(ctrl_sr);

  adc_sdev_edges u_edges (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
  );

  adc_sdev_result #(.RES_W(RES_W)) u_result (
    .sel      (cb.sel),
    .uni      (cb.uni),
    .sgl      (cb.sgl),
    .ch_code  (ch_code),
    .com_code (com_code),
    .code     (res_code)
  );

  adc_sdev_serializer #(.CODE_W(RES_W), .PAD_W(PAD_BITS)) u_ser (
    .clk   (clk),
    .rst   (rst),
    .load  (ser_load),
    .shift (ser_shift),
    .code  (res_code),
    .head  (ser_head),
    .last  (ser_last)
  );

  always_comb begin
    fire_rise = sclk_rise && !cs_n;
    fire_fall = sclk_fall && !cs_n;
    busy_done = (state == ST_IBUSY) && (busy_cnt == CNT_W'(CONV_CYCLES - 1));
    latch     = (state == ST_CTRL) && fire_fall && (ctrl_cnt == BCNT_W'(CTRL_BITS));
    ser_load  = latch && cb.pmode[1];
    ser_shift = busy_done ||
                (fire_fall && ((state == ST_EXT) || (state == ST_IOUT)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_SEARCH;
      ctrl_sr  <= '0;
      ctrl_cnt <= '0;
      busy_cnt <= '0;
      int_mode <= 1'b0;
      dout     <= 1'b0;
      dout_oe  <= 1'b0;
      sstrb    <= 1'b0;
      sstrb_oe <= 1'b0;
      acq      <= 1'b0;
    end else begin
      dout_oe  <= !cs_n;
      sstrb_oe <= !cs_n || int_mode;
      if (state == ST_IBUSY) begin
        if (busy_done) begin
          state <= ST_IOUT;
          sstrb <= 1'b1;
          dout  <= ser_head;
        end else begin
          busy_cnt <= busy_cnt + CNT_W'(1);
        end
      end else if (cs_n) begin
        state    <= ST_SEARCH;
        ctrl_cnt <= '0;
        acq      <= 1'b0;
        dout     <= 1'b0;
        if (!int_mode) sstrb <= 1'b0;
      end else begin
        unique case (state)
          ST_SEARCH: begin
            if (fire_rise && din) begin
              ctrl_sr  <= CTRL_BITS'(1);
              ctrl_cnt <= BCNT_W'(1);
              state    <= ST_CTRL;
            end
          end
          ST_CTRL: begin
            if (fire_rise) begin
              ctrl_sr  <= {ctrl_sr[CTRL_BITS-2:0], din};
              ctrl_cnt <= ctrl_cnt + BCNT_W'(1);
            end else if (fire_fall) begin
              if (ctrl_cnt == BCNT_W'(TRACK_AT)) acq <= 1'b1;
              if (latch) begin
                acq      <= 1'b0;
                ctrl_cnt <= '0;
                busy_cnt <= '0;
                unique case (pmode_e'(cb.pmode))
                  PM_EXT_CLK: begin
                    state    <= ST_EXT;
                    sstrb    <= 1'b1;
                    int_mode <= 1'b0;
                  end
                  PM_INT_CLK: begin
                    state    <= ST_IBUSY;
                    sstrb    <= 1'b0;
                    int_mode <= 1'b1;
                  end
                  default: begin
                    state    <= ST_SEARCH;
                    sstrb    <= 1'b0;
                    int_mode <= 1'b0;
                  end
                endcase
              end
            end
          end
          ST_EXT: begin
            if (fire_fall) begin
              sstrb <= 1'b0;
              dout  <= ser_head;
              if (ser_last) state <= ST_SEARCH;
            end
          end
          ST_IOUT: begin
            if (fire_fall) begin
              dout <= ser_head;
              if (ser_last) state <= ST_SEARCH;
            end
          end
          default: state <= ST_SEARCH;
        endcase
      end
    end
  end

  // R1: the start bit collected on leaving search sits at the count position
  p_start_pos_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CTRL) |-> ctrl_sr[3'(ctrl_cnt - BCNT_W'(1))]);

  // R1: a command that reached conversion carries its start bit at the top
  p_start_kept_r1: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_EXT) || (state == ST_IBUSY)) |-> cb.start);

  // R5: the track window only exists while a command is being collected
  p_acq_in_ctrl_r5: assert property (@(posedge clk) disable iff (rst)
    acq |-> (state == ST_CTRL));

  // R6: an external-mode strobe is only seen while the result frame is pending
  p_sstrb_ext_r6: assert property (@(posedge clk) disable iff (rst)
    (sstrb && !int_mode) |-> (state == ST_EXT));

  // R9: the strobe reads busy for the whole internal conversion
  p_busy_low_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IBUSY) |-> !sstrb);

  // R10: chip select high never leaves a serial transfer in progress
  p_abort_r10: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ((state != ST_CTRL) && (state != ST_EXT)));
endmodule

// File: tb/adc_serial_dev_bench.sv
module adc_serial_dev_bench;
  localparam int RES_W = 10;
  localparam int CONV  = 64;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [RES_W-1:0] chv [8];
  logic [RES_W-1:0] com = '0;
  logic [8*RES_W-1:0] ch_flat;
  logic dout, dout_oe, sstrb, sstrb_oe, acq;

  always_comb begin
    for (int i = 0; i < 8; i++) ch_flat[i*RES_W +: RES_W] = chv[i];
  end

  always #2 clk = ~clk;

  adc_serial_dev #(.RES_W(RES_W), .CONV_CYCLES(CONV)) u_adc_serial_dev (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .ch_code(ch_flat), .com_code(com),
    .dout(dout), .dout_oe(dout_oe), .sstrb(sstrb), .sstrb_oe(sstrb_oe), .acq(acq)
  );

  int n_vec = 0, n_bad = 0;

  typedef struct {
    string tag;
    logic [3:0] exp;
  } item_t;
  item_t q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected {oe, dout, sstrb, acq} at every rising sclk
  always @(posedge sclk) begin
    item_t it;
    if (q.size() > 0) begin
      it = q.pop_front();
      chk(it.tag, {28'd0, dout_oe, dout, sstrb, acq}, {28'd0, it.exp});
    end
  end

  // driver: one serial clock period, expectation pushed before the edge
  task automatic sbit(logic b, string tag, logic ed, logic es, logic ea);
    item_t it;
    @(negedge clk);
    din = b;
    it.tag = tag;
    it.exp = {1'b1, ed, es, ea};
    q.push_back(it);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic raw_pulse(logic b);
    @(negedge clk);
    din = b; sclk = 1'b1;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    repeat (3) @(negedge clk);
    din = 1'b0;
  endtask

  function automatic logic [RES_W-1:0] ref_code(logic [2:0] sel, logic uni, logic sgl);
    int p, n, d;
    p = int'(chv[{sel[1:0], sel[2]}]);
    n = sgl ? int'(com) : int'(chv[{sel[1:0], ~sel[2]}]);
    d = p - n;
    if (uni) begin
      if (d < 0) d = 0;
    end else begin
      if (d > 511) d = 511;
      if (d < -512) d = -512;
    end
    return RES_W'(d);
  endfunction

  task automatic cs_fall(logic exp_sstrb);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 dout_oe after cs fall", {31'd0, dout_oe}, 32'd1);
    chk("R8 sstrb_oe after cs fall", {31'd0, sstrb_oe}, 32'd1);
    chk("R8 sstrb level after cs fall", {31'd0, sstrb}, {31'd0, exp_sstrb});
  endtask

  task automatic cs_rise(logic exp_soe);
    @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 dout_oe after cs rise", {31'd0, dout_oe}, 32'd0);
    chk("R8 sstrb_oe after cs rise", {31'd0, sstrb_oe}, {31'd0, exp_soe});
  endtask

  // command bits; acq expected on risings 6..8 (R5), strobe level es throughout
  task automatic send_cmd(logic [7:0] cmd, logic es);
    for (int k = 1; k <= 8; k++)
      sbit(cmd[8-k], $sformatf("R2 R5 cmd bit %0d", k), 1'b0, es, (k >= 6));
  endtask

  task automatic ext_conv(int lead, logic [2:0] sel, logic uni, logic sgl, int stop_at, string tag);
    logic [RES_W-1:0] code;
    logic [RES_W+1:0] frame;
    code  = ref_code(sel, uni, sgl);
    frame = {code, 2'b00};
    for (int i = 0; i < lead; i++) sbit(1'b0, "R1 leading zero", 1'b0, 1'b0, 1'b0);
    send_cmd({1'b1, sel, uni, sgl, 2'b11}, 1'b0);
    sbit(1'b0, "R6 R7 strobe slot", 1'b0, 1'b1, 1'b0);
    for (int k = 10; k <= 21 && k <= stop_at; k++)
      sbit(1'b0, $sformatf("R7 %s frame bit %0d", tag, 21 - k), frame[21-k], 1'b0, 1'b0);
    for (int k = 22; k <= 24 && k <= stop_at; k++)
      sbit(1'b0, "R7 trailing zero", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [RES_W+1:0] iframe;
    chv[0] = 10'd700; chv[1] = 10'd456; chv[2] = 10'd1023; chv[3] = 10'd300;
    chv[4] = 10'd200; chv[5] = 10'd50;  chv[6] = 10'd1000; chv[7] = 10'd10;
    com = 10'd100;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 reset outputs", {27'd0, dout, dout_oe, sstrb, sstrb_oe, acq}, 32'd0);

    // external conversions, unipolar/bipolar, single-ended/differential
    cs_fall(1'b0);
    ext_conv(0, 3'b000, 1'b1, 1'b1, 24, "R3 R4 se-uni");
    com = 10'd512;
    ext_conv(5, 3'b101, 1'b0, 1'b1, 24, "R1 R3 R4 se-bip neg");
    ext_conv(0, 3'b110, 1'b1, 1'b0, 24, "R3 R4 diff-uni clamp0");
    ext_conv(2, 3'b010, 1'b0, 1'b0, 24, "R3 R4 diff-bip");
    ext_conv(0, 3'b011, 1'b0, 1'b0, 24, "R4 bip clamp max");
    com = 10'd0;
    ext_conv(0, 3'b001, 1'b1, 1'b1, 24, "R4 uni full scale");
    cs_rise(1'b0);

    // internal clock mode
    cs_fall(1'b0);
    iframe = {ref_code(3'b100, 1'b1, 1'b1), 2'b00};
    send_cmd({1'b1, 3'b100, 1'b1, 1'b1, 2'b10}, 1'b0);
    raw_pulse(1'b1);
    raw_pulse(1'b1);
    repeat (15) @(negedge clk);
    chk("R9 sstrb busy low", {31'd0, sstrb}, 32'd0);
    chk("R9 dout quiet while busy", {31'd0, dout}, 32'd0);
    repeat (50) @(negedge clk);
    chk("R9 sstrb done high", {31'd0, sstrb}, 32'd1);
    chk("R9 msb at done", {31'd0, dout}, {31'd0, iframe[11]});
    for (int j = 1; j <= 12; j++)
      sbit(1'b0, $sformatf("R9 internal frame bit %0d", 12 - j), iframe[12-j], 1'b1, 1'b0);
    cs_rise(1'b1);

    // power-down bytes, then a conversion in the same frame
    cs_fall(1'b1);
    send_cmd({1'b1, 3'b000, 1'b1, 1'b1, 2'b00}, 1'b1);
    for (int i = 0; i < 4; i++) sbit(1'b0, "R11 full power-down silent", 1'b0, 1'b0, 1'b0);
    send_cmd({1'b1, 3'b000, 1'b1, 1'b1, 2'b01}, 1'b0);
    for (int i = 0; i < 4; i++) sbit(1'b0, "R11 fast power-down silent", 1'b0, 1'b0, 1'b0);
    ext_conv(0, 3'b111, 1'b1, 1'b1, 24, "R11 after power-down");
    cs_rise(1'b0);

    // abort mid-read, then a different channel
    cs_fall(1'b0);
    ext_conv(0, 3'b000, 1'b1, 1'b1, 13, "R10 partial");
    cs_rise(1'b0);
    chk("R10 dout low after abort", {31'd0, dout}, 32'd0);
    cs_fall(1'b0);
    ext_conv(1, 3'b001, 1'b1, 1'b0, 24, "R10 after abort");
    cs_rise(1'b0);

    repeat (5) @(negedge clk);
    chk("R7 all expectations consumed", q.size(), 32'd0);
    finish_run();
  end
endmodule